// File: doc/BRIEF.md
# USB Clock Request and Wake Controller

This block decides when the clocks of a USB host/device controller pair must run. It watches DMA memory accesses from both controllers, the host's functional state and two bus events (resume signaling and disconnect). From these it raises hardware clock requests for two domains: the 48 MHz host clock and the AHB master clock. Each domain's clock-on request is the OR of its hardware request and a software enable bit. Software can therefore clear its enable bits during normal operation and the controllers still get their clocks when they need them.

A DMA access keeps the AHB master clock requested for two USB frames. The hold restarts on every new access, so the window always counts from the most recent access. The host clock is requested whenever the host is not suspended. While suspended, it is requested only if resume or disconnect is detected on the bus. All hardware requests are combined into one need-clock status that software can poll before entering power-down. When waking is enabled, a rise of this status produces a one-cycle wake pulse. Each domain also has a clock-on status bit that follows its clock-on request through a two-flop synchronizer.

Top module: `usbclk_req_ctrl`

## Requirements
- R1: A DMA need request (`dev_dma_need`, `host_dma_need`) is high in the cycle after its access strobe. It stays high until the second `frame_tick` after the last access, and it is low from the cycle after that second tick.
- R2: An access while a hold is running restarts the two-tick window. An access in the same cycle as a `frame_tick` reloads the window, and that tick is not counted.
- R3: `host_state` is encoded 00 reset, 01 resume, 10 operational, 11 suspend. Any code other than 11 makes `host_need` high in the next cycle.
- R4: With `host_state` = 11, `host_need` is high in the next cycle if `bus_resume` or `bus_disconnect` is high, and low otherwise.
- R5: `host_clk_req` equals `sw_host_clk_en` OR `host_need`. `ahb_clk_req` equals `sw_ahb_clk_en` OR either DMA need request.
- R6: `need_clk` is the OR of `host_need`, `dev_dma_need` and `host_dma_need`. The software enable bits do not affect it.
- R7: `wake_pulse` is high for exactly the cycle in which `need_clk` rises, and only if `wake_en` is high in that cycle.
- R8: `host_clk_on` and `ahb_clk_on` equal their clock-on request as it was two cycles earlier.
- R9: While `rst` is sampled high at a clock edge, all hold timers, `host_need`, both clock-on status bits and the wake edge detector are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_dma_access | input | 1 | Device controller DMA memory access strobe |
| host_dma_access | input | 1 | Host controller DMA memory access strobe |
| frame_tick | input | 1 | One-cycle pulse once per 1 ms USB frame |
| host_state | input | 2 | Host functional state code |
| bus_resume | input | 1 | Resume signaling detected on the bus |
| bus_disconnect | input | 1 | Disconnect detected on the bus |
| sw_host_clk_en | input | 1 | Software enable for the 48 MHz host clock |
| sw_ahb_clk_en | input | 1 | Software enable for the AHB master clock |
| wake_en | input | 1 | Allows a need-clock rise to wake from power-down |
| dev_dma_need | output | 1 | Device DMA hold request |
| host_dma_need | output | 1 | Host DMA hold request |
| host_need | output | 1 | Host 48 MHz clock hardware request |
| host_clk_req | output | 1 | Clock-on request for the 48 MHz host clock |
| ahb_clk_req | output | 1 | Clock-on request for the AHB master clock |
| host_clk_on | output | 1 | Synchronized clock-on status, host domain |
| ahb_clk_on | output | 1 | Synchronized clock-on status, AHB domain |
| need_clk | output | 1 | Combined hardware need-clock status |
| wake_pulse | output | 1 | One-cycle wake request from power-down |

## Verification
The assertions assume every input is synchronous to `clk`. They also assume `frame_tick` is a single-cycle pulse. The hold-timer properties rely on ticks being sampled only at clock edges. The bench drives every input one time unit after a rising edge, and all its stimulus comes from a registered pseudo-random sequence. This keeps the stimulus synchronous and lets ticks fall in the same cycle as accesses, which exercises the reload rule. Activity densities are chosen so that holds both expire and get retriggered. Mid-run resets are applied while requests are live.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;

    typedef enum logic [1:0] {
        HST_RESET   = 2'b00,
        HST_RESUME  = 2'b01,
        HST_OPER    = 2'b10,
        HST_SUSPEND = 2'b11
    } host_fs_e;

    typedef struct packed {
        logic host48;
        logic ahb;
    } clk_dom_t;

    localparam int NUM_DMA_SRC = 2;
    localparam int DMA_DEV     = 0;
    localparam int DMA_HOST    = 1;

    function automatic logic host_wants_clk(host_fs_e st, logic resume, logic disc);
        return (st != HST_SUSPEND) || resume || disc;
    endfunction

endpackage

// File: rtl/usbclk_hold_timer.sv
module usbclk_hold_timer #(
    parameter int HOLD_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic access,
    input  logic frame_tick,
    output logic active
);
    localparam int CW = $clog2(HOLD_FRAMES + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_FRAMES);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (access)
            remain_q <= LOAD;
        else if (frame_tick && (remain_q != '0))
            remain_q <= remain_q - 1'b1;
    end

    assign active = (remain_q != '0);

    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
        access |=> (remain_q == LOAD) && active);                 // R2
    AST_HOLD_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (rst)
        (active && !frame_tick && !access) |=> active);           // R1
    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
        remain_q <= LOAD);                                        // R1

endmodule

// File: rtl/usbclk_sync.sv
module usbclk_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/usbclk_req_ctrl.sv
module usbclk_req_ctrl
    import usbclk_pkg::*;
#(
    parameter int HOLD_FRAMES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dev_dma_access,
    input  logic       host_dma_access,
    input  logic       frame_tick,
    input  logic [1:0] host_state,
    input  logic       bus_resume,
    input  logic       bus_disconnect,
    input  logic       sw_host_clk_en,
    input  logic       sw_ahb_clk_en,
    input  logic       wake_en,
    output logic       dev_dma_need,
    output logic       host_dma_need,
    output logic       host_need,
    output logic       host_clk_req,
    output logic       ahb_clk_req,
    output logic       host_clk_on,
    output logic       ahb_clk_on,
    output logic       need_clk,
    output logic       wake_pulse
);
    logic [NUM_DMA_SRC-1:0] dma_acc;
    logic [NUM_DMA_SRC-1:0] dma_hold;
    logic                   host_need_q;
    logic                   need_d_q;
    clk_dom_t               req_s;
    clk_dom_t               on_s;

    assign dma_acc[DMA_DEV]  = dev_dma_access;
    assign dma_acc[DMA_HOST] = host_dma_access;

    for (genvar g = 0; g < NUM_DMA_SRC; g++) begin : g_hold
        usbclk_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
            .clk        (clk),
            .rst        (rst),
            .access     (dma_acc[g]),
            .frame_tick (frame_tick),
            .active     (dma_hold[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_need_q <= 1'b0;
            need_d_q    <= 1'b0;
        end else begin
            host_need_q <= host_wants_clk(host_fs_e'(host_state), bus_resume, bus_disconnect);
            need_d_q    <= need_clk;
        end
    end

    assign dev_dma_need  = dma_hold[DMA_DEV];
    assign host_dma_need = dma_hold[DMA_HOST];
    assign host_need     = host_need_q;
    assign need_clk      = host_need_q | (|dma_hold);

    assign req_s.host48 = sw_host_clk_en | host_need_q;
    assign req_s.ahb    = sw_ahb_clk_en | (|dma_hold);
    assign host_clk_req = req_s.host48;
    assign ahb_clk_req  = req_s.ahb;

    usbclk_sync #(.STAGES(SYNC_STAGES), .WIDTH($bits(clk_dom_t))) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (req_s),
        .dout (on_s)
    );

    assign host_clk_on = on_s.host48;
    assign ahb_clk_on  = on_s.ahb;

    assign wake_pulse = wake_en & need_clk & ~need_d_q;

    AST_HOST_AWAKE: assert property (@(posedge clk) disable iff (rst)
        (host_state != HST_SUSPEND) |=> host_need);                           // R3
    AST_SUSP_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        ((host_state == HST_SUSPEND) && (bus_resume || bus_disconnect)) |=> host_need); // R4
    AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((host_state == HST_SUSPEND) && !bus_resume && !bus_disconnect) |=> !host_need); // R4
    AST_DMA_TO_AHB: assert property (@(posedge clk) disable iff (rst)
        (dev_dma_access || host_dma_access) |=> (ahb_clk_req && need_clk));  // R5
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);                                          // R7
    AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (wake_en && need_clk));                                // R7
    AST_NEED_HW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!host_need && !dev_dma_need && !host_dma_need) |-> !need_clk);       // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!need_clk && !host_clk_on && !ahb_clk_on));                  // R9

endmodule

// File: tb/usbclk_req_ctrl_tb.sv
module usbclk_req_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dev_acc = 0, host_acc = 0, tick = 0, res = 0, disc = 0;
    logic sw_h = 0, sw_a = 0, wen = 0;
    logic [1:0] hst = 2'b00;
    logic dev_need, hdma_need, h_need, h_req, a_req, h_on, a_on, need, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench-side expectations
    int m_dc = 0, m_hc = 0;
    bit m_hn = 0, m_nd = 0;
    bit m_s1h = 0, m_s1a = 0, m_s2h = 0, m_s2a = 0;
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    usbclk_req_ctrl u_dut (
        .clk(clk), .rst(rst),
        .dev_dma_access(dev_acc), .host_dma_access(host_acc),
        .frame_tick(tick), .host_state(hst),
        .bus_resume(res), .bus_disconnect(disc),
        .sw_host_clk_en(sw_h), .sw_ahb_clk_en(sw_a), .wake_en(wen),
        .dev_dma_need(dev_need), .host_dma_need(hdma_need), .host_need(h_need),
        .host_clk_req(h_req), .ahb_clk_req(a_req),
        .host_clk_on(h_on), .ahb_clk_on(a_on),
        .need_clk(need), .wake_pulse(wake)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: advance expectations and the DUT together
    task automatic cyc();
        bit pre_h, pre_a, pre_n;
        pre_h = sw_h | m_hn;
        pre_a = sw_a | (m_dc > 0) | (m_hc > 0);
        pre_n = m_hn | (m_dc > 0) | (m_hc > 0);
        @(posedge clk); #1;
        if (rst) begin
            m_dc = 0; m_hc = 0; m_hn = 0; m_nd = 0;
            m_s1h = 0; m_s1a = 0; m_s2h = 0; m_s2a = 0;
        end else begin
            m_s2h = m_s1h; m_s2a = m_s1a; m_s1h = pre_h; m_s1a = pre_a;
            m_nd = pre_n;
            if (dev_acc) m_dc = 2; else if (tick && m_dc > 0) m_dc--;
            if (host_acc) m_hc = 2; else if (tick && m_hc > 0) m_hc--;
            m_hn = (hst != 2'b11) || res || disc;
        end
    endtask

    task automatic compare_all();
        bit en;
        en = m_hn | (m_dc > 0) | (m_hc > 0);
        chk("R1 R2 dev_dma_need", dev_need, m_dc > 0);
        chk("R1 R2 host_dma_need", hdma_need, m_hc > 0);
        chk("R3 R4 host_need", h_need, m_hn);
        chk("R5 host_clk_req", h_req, sw_h | m_hn);
        chk("R5 ahb_clk_req", a_req, sw_a | (m_dc > 0) | (m_hc > 0));
        chk("R6 need_clk", need, en);
        chk("R7 wake_pulse", wake, wen & en & ~m_nd);
        chk("R8 host_clk_on", h_on, m_s2h);
        chk("R8 ahb_clk_on", a_on, m_s2a);
    endtask

    task automatic idle();
        dev_acc = 0; host_acc = 0; tick = 0; res = 0; disc = 0;
    endtask

    initial begin
        // R9: reset state
        hst = 2'b00; sw_h = 1; sw_a = 1;
        repeat (3) cyc();
        chk("R9 reset need_clk", need, 1'b0);
        chk("R9 reset host_clk_on", h_on, 1'b0);
        chk("R9 reset ahb_clk_on", a_on, 1'b0);
        chk("R9 reset dev_dma_need", dev_need, 1'b0);
        sw_h = 0; sw_a = 0;
        hst = 2'b11;
        cyc(); rst = 0;

        // R1: exact hold length, directed
        cyc(); idle();
        dev_acc = 1; cyc(); dev_acc = 0;
        chk("R1 rise after access", dev_need, 1'b1);
        cyc(); chk("R1 holds without tick", dev_need, 1'b1);
        tick = 1; cyc(); tick = 0;
        chk("R1 holds after first tick", dev_need, 1'b1);
        cyc(); tick = 1; cyc(); tick = 0;
        chk("R1 drops after second tick", dev_need, 1'b0);

        // R2: access with tick reloads and the tick is not counted
        host_acc = 1; cyc(); host_acc = 0;
        tick = 1; cyc(); tick = 0;
        host_acc = 1; tick = 1; cyc(); host_acc = 0; tick = 0;
        tick = 1; cyc(); tick = 0;
        chk("R2 reload ignores coinciding tick", hdma_need, 1'b1);
        tick = 1; cyc(); tick = 0;
        chk("R2 drop two ticks after last access", hdma_need, 1'b0);

        // R3 R4: sweep of state x resume x disconnect
        for (int k = 0; k < 16; k++) begin
            hst = k[1:0]; res = k[2]; disc = k[3];
            cyc();
            chk("R3 R4 host_need sweep", h_need, (k[1:0] != 2'b11) || k[2] || k[3]);
        end
        idle(); hst = 2'b11; cyc(); cyc();

        // R7: wake qualified by wake_en
        wen = 0; hst = 2'b10; cyc();
        chk("R7 no wake when disabled", wake, 1'b0);
        hst = 2'b11; cyc(); cyc();
        wen = 1; hst = 2'b10; cyc();
        chk("R7 wake on need rise", wake, 1'b1);
        cyc(); chk("R7 wake single cycle", wake, 1'b0);
        hst = 2'b11; cyc(); cyc();

        // randomized sweep with continuous comparison
        for (int n = 0; n < 6000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            dev_acc  = (n < 3000) ? (lf[2:0] == 3'b111) : (lf[4:0] == 5'h1F);
            host_acc = (n < 3000) ? (lf[5:3] == 3'b101) : (lf[9:5] == 5'h0A);
            tick     = (lf[7:6] == 2'b11);
            if (lf[11:8] == 4'hF) hst = lf[13:12];
            res  = (lf[14:12] == 3'b000);
            disc = (lf[15:13] == 3'b110) && lf[0];
            if (lf[9:4] == 6'h21) sw_h = ~sw_h;
            if (lf[10:5] == 6'h13) sw_a = ~sw_a;
            if (lf[12:7] == 6'h2A) wen = ~wen;
            rst = (n % 997 == 500) || (n % 997 == 501);
            cyc();
            compare_all();
        end
        rst = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule